// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a scratchpad memory that is cut into 32 banks, each able to take one access per clock. It takes one group-wide request at a time: 32 lane word addresses, a lane enable mask, a read/write flag and, for writes, 32 lane data words. Each address's low five bits pick its bank and the remaining bits pick the row inside that bank.

Lanes whose addresses fall in different banks are served together. Lanes that share a bank are spread over successive rounds. In every round each bank takes the lowest-numbered lane still waiting on it. The block holds `busy` while rounds remain and ignores new requests during that time. It then pulses `done` once. Read results are collected per lane in a holding register and stay on `rdata` until the next request is accepted.

A group with no bank sharing finishes in one round. A group where every enabled lane targets one bank takes as many rounds as there are such lanes, so 32 for a full group hitting a single word.

Top module: `smem_bank_arbiter`

## Requirements
- R1: A word address maps to bank `addr[4:0]` (address modulo 32) and to row `addr[8:5]`; lanes in different banks never delay each other.
- R2: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0, and `busy` is 1 from the next cycle on. While `busy` is 1, requests are ignored and have no effect on storage or results.
- R3: If all enabled lanes map to distinct banks, `busy` stays high for exactly one cycle.
- R4: The number of cycles `busy` stays high equals the largest count of enabled lanes sharing one bank (32 for a full group on one word).
- R5: In each round a bank serves its lowest-numbered waiting lane. When several enabled lanes write the same word, the highest-numbered lane's data remains.
- R6: `done` is a one-cycle pulse in the first cycle after the final round, with `busy` already 0 in that cycle.
- R7: After `done`, each enabled lane of a read request shows the word last written to its address on its slice `rdata[32*l+31:32*l]`, and that value holds until the next request is taken.
- R8: Disabled lanes never touch storage, and their `rdata` slices read zero. Every `rdata` slice reads zero after a write request and after reset.
- R9: A request with an all-zero mask holds `busy` for one cycle, then pulses `done`, and accesses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 32 | Lane enables, bit l for lane l |
| req_addr | input | 288 | Lane word addresses, 9 bits per lane, lane l at [9l+8:9l] |
| req_wdata | input | 1024 | Lane write data, 32 bits per lane, lane l at [32l+31:32l] |
| busy | output | 1 | Rounds outstanding, requests refused |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 1024 | Per-lane read results, lane l at [32l+31:32l] |

## Verification
A wrong waiting-lane set or a wrong bank pick shows up at the ports when the request completes. `busy` then stays high for the wrong number of cycles, or a lane's `rdata` slice holds a word from the wrong address. A lost write stays hidden in storage until a later read of that word returns the old value. The bench therefore reads every address class again after random writes and compares against its own memory image. A refused request that slips through shows up either as a corrupted word on a later read or as `done` and `busy` timing that no longer matches the bank counts of the original request.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic {
    SMEM_RD = 1'b0,
    SMEM_WR = 1'b1
  } smem_op_e;
endpackage

// File: rtl/smem_bank.sv
module smem_bank #(
  parameter int ROW_BITS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] row,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ROW_BITS;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[row] <= wdata;
  end

  assign rdata = cells[row];
endmodule

// File: rtl/smem_round_picker.sv
module smem_round_picker #(
  parameter int NUM_LANES = 32,
  parameter int BANK_BITS = 5,
  parameter int LANE_W    = 5
) (
  input  logic [NUM_LANES-1:0]           pending,
  input  logic [NUM_LANES*BANK_BITS-1:0] lane_bank,
  output logic [(1<<BANK_BITS)-1:0]      bank_en,
  output logic [(1<<BANK_BITS)*LANE_W-1:0] bank_lane,
  output logic [NUM_LANES-1:0]           lane_grant
);
  localparam int NUM_BANKS = 1 << BANK_BITS;

  // Walk lanes from the top down so the lowest waiting lane is written last.
  always_comb begin
    bank_en   = '0;
    bank_lane = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int l = NUM_LANES - 1; l >= 0; l--) begin
        if (pending[l] && (lane_bank[l*BANK_BITS +: BANK_BITS] == BANK_BITS'(b))) begin
          bank_en[b] = 1'b1;
          bank_lane[b*LANE_W +: LANE_W] = LANE_W'(l);
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      logic [BANK_BITS-1:0] bk;
      bk = lane_bank[l*BANK_BITS +: BANK_BITS];
      lane_grant[l] = pending[l] && bank_en[bk] &&
                      (bank_lane[bk*LANE_W +: LANE_W] == LANE_W'(l));
    end
  end
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
  import smem_pkg::*;
#(
  parameter int NUM_LANES = 32,
  parameter int BANK_BITS = 5,
  parameter int ROW_BITS  = 4,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [NUM_LANES-1:0]          req_mask,
  input  logic [NUM_LANES*(BANK_BITS+ROW_BITS)-1:0] req_addr,
  input  logic [NUM_LANES*DATA_W-1:0]   req_wdata,
  output logic                          busy,
  output logic                          done,
  output logic [NUM_LANES*DATA_W-1:0]   rdata
);
  localparam int NUM_BANKS = 1 << BANK_BITS;
  localparam int ADDR_W    = BANK_BITS + ROW_BITS;
  localparam int LANE_W    = $clog2(NUM_LANES);

  function automatic logic [BANK_BITS-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_BITS-1:0];
  endfunction

  function automatic logic [ROW_BITS-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BANK_BITS];
  endfunction

  // Captured request
  logic [ADDR_W-1:0]    addr_q  [NUM_LANES];
  logic [DATA_W-1:0]    wdata_q [NUM_LANES];
  logic [DATA_W-1:0]    rdata_q [NUM_LANES];
  logic [NUM_LANES-1:0] mask_q;
  logic [NUM_LANES-1:0] pending_q;
  smem_op_e             op_q;
  logic                 busy_q;
  logic                 done_q;

  // Named internal events
  logic                 accept;
  logic                 last_round;
  logic                 is_write;
  logic [NUM_LANES-1:0] remain;
  logic [NUM_LANES-1:0] lane_grant;
  logic [NUM_BANKS-1:0] bank_en;
  logic [NUM_BANKS-1:0] bank_wr;
  logic [NUM_BANKS*LANE_W-1:0]    bank_lane;
  logic [NUM_LANES*BANK_BITS-1:0] lane_bank_flat;
  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

  assign accept     = req_valid && !busy_q;
  assign is_write   = (op_q == SMEM_WR);
  assign remain     = pending_q & ~lane_grant;
  assign last_round = busy_q && (remain == '0);

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      lane_bank_flat[l*BANK_BITS +: BANK_BITS] = bank_of(addr_q[l]);
    end
  end

  smem_round_picker #(
    .NUM_LANES (NUM_LANES),
    .BANK_BITS (BANK_BITS),
    .LANE_W    (LANE_W)
  ) u_picker (
    .pending    (pending_q),
    .lane_bank  (lane_bank_flat),
    .bank_en    (bank_en),
    .bank_lane  (bank_lane),
    .lane_grant (lane_grant)
  );

  // Bank-side crossbar: each bank takes the address and data of its chosen lane
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LANE_W-1:0] sel;
    assign sel        = bank_lane[b*LANE_W +: LANE_W];
    assign bank_wr[b] = busy_q && is_write && bank_en[b];

    smem_bank #(
      .ROW_BITS (ROW_BITS),
      .DATA_W   (DATA_W)
    ) u_bank (
      .clk   (clk),
      .wr_en (bank_wr[b]),
      .row   (row_of(addr_q[sel])),
      .wdata (wdata_q[sel]),
      .rdata (bank_rdata[b])
    );
  end

  // Control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      pending_q <= '0;
      mask_q    <= '0;
      op_q      <= SMEM_RD;
    end else begin
      done_q <= last_round;
      if (accept) begin
        busy_q    <= 1'b1;
        pending_q <= req_mask;
        mask_q    <= req_mask;
        op_q      <= req_write ? SMEM_WR : SMEM_RD;
      end else if (busy_q) begin
        pending_q <= remain;
        if (last_round) busy_q <= 1'b0;
      end
    end
  end

  // Request payload capture
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
        wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
      end
    end
  end

  // Lane-side crossbar: served read lanes collect their bank's word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LANES; l++) rdata_q[l] <= '0;
    end else begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (accept) begin
          rdata_q[l] <= '0;
        end else if (busy_q && !is_write && lane_grant[l]) begin
          rdata_q[l] <= bank_rdata[bank_of(addr_q[l])];
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_out
    assign rdata[l*DATA_W +: DATA_W] = rdata_q[l];
  end
endmodule

// File: rtl/smem_bank_arbiter_chk.sv
module smem_bank_arbiter_chk #(
  parameter int NUM_LANES = 32,
  parameter int NUM_BANKS = 32,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        busy,
  input logic                        done,
  input logic                        last_round,
  input logic                        is_write,
  input logic [NUM_LANES-1:0]        mask_q,
  input logic [NUM_LANES-1:0]        pending_q,
  input logic [NUM_LANES-1:0]        lane_grant,
  input logic [NUM_BANKS-1:0]        bank_wr,
  input logic [NUM_LANES*DATA_W-1:0] rdata
);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  p_refuse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_round |=> $stable(mask_q));

  p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (pending_q != '0) |-> (lane_grant != '0));

  p_grant_waiting_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((lane_grant & ~pending_q) == '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_write |-> (bank_wr == '0));

  p_empty_one_round_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (pending_q == '0) |-> last_round);

  always @(posedge clk) begin
    if (rst_n && done) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (!mask_q[l]) begin
          p_inactive_zero_r8: assert (rdata[l*DATA_W +: DATA_W] == '0);
        end
      end
    end
  end
endmodule

bind smem_bank_arbiter smem_bank_arbiter_chk #(
  .NUM_LANES (NUM_LANES),
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .last_round (last_round),
  .is_write   (is_write),
  .mask_q     (mask_q),
  .pending_q  (pending_q),
  .lane_grant (lane_grant),
  .bank_wr    (bank_wr),
  .rdata      (rdata)
);

// File: tb/smem_bank_arbiter_tb_top.sv
module smem_bank_arbiter_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 9;
  localparam int DW    = 32;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [LANES-1:0]    req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [LANES*DW-1:0] rdata;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] model [WORDS];
  logic [AW-1:0] addr_v [LANES];
  logic [DW-1:0] data_v [LANES];

  always #4 clk = ~clk;

  smem_bank_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int expect_rounds(input logic [LANES-1:0] m);
    int cnt [LANES];
    int mx = 0;
    for (int b = 0; b < LANES; b++) cnt[b] = 0;
    for (int l = 0; l < LANES; l++) if (m[l]) cnt[addr_v[l] % 32]++;
    for (int b = 0; b < LANES; b++) if (cnt[b] > mx) mx = cnt[b];
    return (mx == 0) ? 1 : mx;
  endfunction

  task automatic run_req(input bit wr, input logic [LANES-1:0] m, input bit inject, input string cyc_tag);
    logic [DW-1:0] exp_rd [LANES];
    logic [LANES*DW-1:0] snap;
    int exp_cyc;
    int cyc = 0;
    bit rd_ok = 1'b1;
    int bad_l = 0;
    exp_cyc = expect_rounds(m);
    for (int l = 0; l < LANES; l++) exp_rd[l] = (m[l] && !wr) ? model[addr_v[l]] : '0;
    if (wr) for (int l = 0; l < LANES; l++) if (m[l]) model[addr_v[l]] = data_v[l];

    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_mask  = m;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW]  = addr_v[l];
      req_wdata[l*DW +: DW] = data_v[l];
    end
    @(negedge clk);
    if (inject) begin
      // R2: an offer during busy must be ignored
      req_write = 1'b1;
      req_mask  = '1;
      for (int l = 0; l < LANES; l++) req_wdata[l*DW +: DW] = 32'hBAD0_0000 | l;
    end else begin
      req_valid = 1'b0;
    end
    while (busy && cyc < 64) begin
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(cyc_tag, "busy cycles", cyc, exp_cyc);
    check("R6", "done after last round", {63'd0, done}, 64'd1);
    for (int l = 0; l < LANES; l++) begin
      if (rd_ok && rdata[l*DW +: DW] !== exp_rd[l]) begin
        rd_ok = 1'b0;
        bad_l = l;
      end
    end
    if (wr || m != '1) begin
      checks++;
      if (!rd_ok) begin
        failures++;
        $display("FAIL R8 lane %0d rdata: got %0h expected %0h", bad_l, rdata[bad_l*DW +: DW], exp_rd[bad_l]);
      end
    end else begin
      check("R7", "rdata lane", rd_ok ? 64'd1 : {32'd0, rdata[bad_l*DW +: DW]}, rd_ok ? 64'd1 : {32'd0, exp_rd[bad_l]});
    end
    snap = rdata;
    @(negedge clk);
    check("R6", "done single pulse", {63'd0, done}, 64'd0);
    check("R7", "rdata held", {63'd0, (rdata == snap)}, 64'd1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20251);
    repeat (4) @(negedge clk);
    // Reset state
    check("R2", "busy after reset", {63'd0, busy}, 64'd0);
    check("R6", "done after reset", {63'd0, done}, 64'd0);
    check("R8", "rdata after reset", {63'd0, (rdata == '0)}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every word, conflict-free stride 1 (R1, R3)
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) begin
        addr_v[l] = AW'(r * LANES + l);
        data_v[l] = $urandom;
      end
      run_req(1'b1, '1, 1'b0, "R3");
    end

    // Conflict-free read back, rotated lane order (R1, R3, R7)
    for (int l = 0; l < LANES; l++) addr_v[l] = AW'(((l + 7) % 32) + 32 * (l % 16));
    run_req(1'b0, '1, 1'b0, "R3");

    // Stride 32: same bank, different rows (R1, R4)
    for (int l = 0; l < LANES; l++) addr_v[l] = AW'(5 + 32 * (l % 16));
    run_req(1'b0, '1, 1'b0, "R1");

    // Stride 2: two lanes per bank (R4)
    for (int l = 0; l < LANES; l++) addr_v[l] = AW'(2 * l);
    run_req(1'b0, '1, 1'b0, "R4");

    // Full group on one word, read (R4)
    for (int l = 0; l < LANES; l++) addr_v[l] = AW'(77);
    run_req(1'b0, '1, 1'b0, "R4");

    // Full group on one word, write with distinct data, with injected offer (R5, R2)
    for (int l = 0; l < LANES; l++) begin
      addr_v[l] = AW'(77);
      data_v[l] = 32'h5500_0000 | l;
    end
    run_req(1'b1, '1, 1'b1, "R4");
    run_req(1'b0, '1, 1'b0, "R5");
    check("R5", "highest lane wins", {32'd0, rdata[DW-1:0]}, {32'd0, 32'h5500_001F});

    // Empty mask (R9) with injected offer during its round
    run_req(1'b0, '0, 1'b1, "R9");
    // Read everything back to see the injected write had no effect (R2)
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) addr_v[l] = AW'(r * LANES + l);
      run_req(1'b0, '1, 1'b0, "R3");
    end

    // Half mask read: disabled lanes zero (R8)
    for (int l = 0; l < LANES; l++) addr_v[l] = AW'(3 * l);
    run_req(1'b0, 32'h0F0F_00FF, 1'b0, "R4");

    // Constrained random
    for (int n = 0; n < 300; n++) begin
      logic [LANES-1:0] m;
      int kind = $urandom % 4;
      int base = $urandom % WORDS;
      for (int l = 0; l < LANES; l++) begin
        case (kind)
          0: addr_v[l] = AW'($urandom);
          1: addr_v[l] = AW'(base + ($urandom % 4) * 32);
          2: addr_v[l] = AW'(base + l * (1 + ($urandom % 2)));
          default: addr_v[l] = AW'(base + ($urandom % 3));
        endcase
        data_v[l] = $urandom;
      end
      m = ($urandom % 3 == 0) ? '1 : LANES'($urandom);
      run_req(1'($urandom % 2), m, 1'($urandom % 5 == 0), "R4");
    end

    // Final read-back of the whole image (R7)
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) addr_v[l] = AW'(r * LANES + l);
      run_req(1'b0, '1, 1'b0, "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog expired: got busy=%0b expected run to end", busy);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule